// File: doc/BRIEF.md
# Sticky Status Register Controller

This block keeps the eight-bit status register of a timekeeping device. Three of its bits are event flags that hardware raises and that stay raised until something clears them: a total loss of power seen at power-up, entry into battery backup, and an alarm match. The other live bits are control settings that software writes directly: an auto-clear enable for the two resettable flags, an external-clock select that turns off the internal oscillator, and an enable that opens the time registers to writes. The two remaining positions are reserved and always read as zero.

Software cannot raise a flag. It can only clear the battery and alarm flags, by writing zero to their positions. When auto-clear is enabled, a completed status read also clears them. The read is marked by a snapshot pulse when the byte is captured for the bus and a done pulse when the transfer ends with STOP. Only flags that were already set at the snapshot are cleared, so an event that lands mid-read survives. The power-loss flag ignores status writes and is cleared by the first write into the time registers. When a hardware event and any clear meet in one cycle, the event wins.

Top module: `tk_status_ctl`

## Requirements
- R1: After reset every bit of `status_q` is 0, and `time_wr_en` and `osc_ext_sel` are 0.
- R2: Bit 0 (power-loss flag) is set one cycle after a `pwr_lost_evt` pulse. It is cleared one cycle after a `time_wr` pulse, and status writes leave it unchanged.
- R3: Bit 1 (battery flag) is set by `bkup_evt` and bit 2 (alarm flag) by `alarm_evt`. Each stays set until a clear named in R4 or R5 occurs.
- R4: A status write with a 0 in bit 1 or bit 2 clears that flag. A 1 in that position leaves the flag as it was and never sets it.
- R5: With bit 7 (auto-clear enable) at 1, an `rd_done` pulse clears bits 1 and 2 if they were set at the latest `rd_snap` pulse, or at an `rd_snap` in the same cycle. With bit 7 at 0, `rd_done` changes nothing. `rd_done` never affects bit 0 or the control bits.
- R6: A battery or alarm event that arrives after the `rd_snap` of a read is still set after that read's `rd_done`, even with auto-clear enabled.
- R7: When a hardware event and a clear by write, `time_wr` or auto-clear reach the same flag in one cycle, the flag is 1 afterwards.
- R8: A status write loads bit 7 (auto-clear enable), bit 6 (external-clock select) and bit 4 (time-write enable) from `wr_data`. `osc_ext_sel` follows bit 6 and `time_wr_en` follows bit 4. Without a write these bits hold.
- R9: Bits 3 and 5 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pwr_lost_evt | input | 1 | Pulse: power-up after a total loss of supply |
| bkup_evt | input | 1 | Pulse: battery backup entered |
| alarm_evt | input | 1 | Pulse: alarm comparison matched |
| wr_stb | input | 1 | Status register write strobe |
| wr_data | input | REG_W | Write data for the status register |
| rd_snap | input | 1 | Pulse: status byte captured for a bus read |
| rd_done | input | 1 | Pulse: status read completed with STOP |
| time_wr | input | 1 | Pulse: a byte was written into the time registers |
| status_q | output | REG_W | Current status register value |
| time_wr_en | output | 1 | Time register write enable (bit 4) |
| osc_ext_sel | output | 1 | Internal oscillator off, external clock selected (bit 6) |

## Verification
Every cycle, the assertions check that each event raises its flag on the next cycle. They also check that flags never rise without an event, that status writes leave the power-loss flag alone, that the reserved positions stay zero, and that the control bits either load or hold. Behaviour that depends on a past read window needs the bench's scenarios. That covers clearing only what the snapshot saw, keeping an alarm that arrived mid-read, and the full cross of event, write-clear and auto-clear with and without the enable. The bench sweeps all 256 write values against set flags and all 32 combinations of the flag's prior state, event, write, read-done and auto-clear enable.

// File: rtl/tk_status_pkg.sv
package tk_status_pkg;
   // Bit positions are decoded by neighbouring logic and software; keep them fixed.
   localparam int unsigned POS_RTCF   = 0;
   localparam int unsigned POS_BAT    = 1;
   localparam int unsigned POS_ALM    = 2;
   localparam int unsigned POS_RSV_LO = 3;
   localparam int unsigned POS_WREN   = 4;
   localparam int unsigned POS_RSV_HI = 5;
   localparam int unsigned POS_XOSC   = 6;
   localparam int unsigned POS_ACLR   = 7;
   localparam int unsigned NUM_FLAGS  = 3;
   localparam int unsigned MIN_REG_W  = 8;

   typedef struct packed {
      logic aclr;
      logic xosc;
      logic wren;
   } ctrl_t;

   function automatic int unsigned flag_pos(input int unsigned idx);
      case (idx)
         0:       return POS_RTCF;
         1:       return POS_BAT;
         default: return POS_ALM;
      endcase
   endfunction
endpackage

// File: rtl/tk_sticky_cell.sv
module tk_sticky_cell #(
   parameter bit AUTO_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic sw_clr_i,
   input  logic auto_en_i,
   input  logic snap_i,
   input  logic done_i,
   output logic flag_o
);
   logic flag_q;
   logic auto_hit;

   generate
      if (AUTO_CLR) begin : g_snap
         logic seen_q;
         logic seen_eff;
         // A snapshot in the same cycle as done uses the live flag value.
         assign seen_eff = snap_i ? flag_q : seen_q;
         assign auto_hit = done_i & auto_en_i & seen_eff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      seen_q <= 1'b0;
            else if (done_i) seen_q <= 1'b0;
            else if (snap_i) seen_q <= flag_q;
         end
      end else begin : g_no_snap
         logic unused_rd;
         assign unused_rd = ^{auto_en_i, snap_i, done_i};
         assign auto_hit  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag_q <= 1'b0;
      else if (set_i)                flag_q <= 1'b1;
      else if (sw_clr_i || auto_hit) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/tk_ctrl_bank.sv
module tk_ctrl_bank
   import tk_status_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_stb_i,
   input  ctrl_t wr_ctrl_i,
   output ctrl_t ctrl_o
);
   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (wr_stb_i) ctrl_q <= wr_ctrl_i;
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tk_status_ctl.sv
module tk_status_ctl
   import tk_status_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_lost_evt,
   input  logic             bkup_evt,
   input  logic             alarm_evt,
   input  logic             wr_stb,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_snap,
   input  logic             rd_done,
   input  logic             time_wr,
   output logic [REG_W-1:0] status_q,
   output logic             time_wr_en,
   output logic             osc_ext_sel
);
   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("tk_status_ctl: REG_W must be at least %0d", MIN_REG_W);
      end
   endgenerate

   logic [NUM_FLAGS-1:0] evt_vec;
   logic [NUM_FLAGS-1:0] flag_vec;
   ctrl_t                ctrl;
   ctrl_t                wr_ctrl;
   logic                 unused_wr;

   assign evt_vec   = {alarm_evt, bkup_evt, pwr_lost_evt};
   assign wr_ctrl   = '{aclr: wr_data[POS_ACLR], xosc: wr_data[POS_XOSC], wren: wr_data[POS_WREN]};
   assign unused_wr = ^wr_data;

   tk_ctrl_bank u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb_i  (wr_stb),
      .wr_ctrl_i (wr_ctrl),
      .ctrl_o    (ctrl)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      localparam int unsigned POS = flag_pos(i);
      if (i == 0) begin : g_pwr
         // Power-loss flag: cleared only by a time-register write.
         tk_sticky_cell #(.AUTO_CLR(1'b0)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (evt_vec[i]),
            .sw_clr_i  (time_wr),
            .auto_en_i (1'b0),
            .snap_i    (1'b0),
            .done_i    (1'b0),
            .flag_o    (flag_vec[i])
         );
      end else begin : g_evt
         tk_sticky_cell #(.AUTO_CLR(1'b1)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (evt_vec[i]),
            .sw_clr_i  (wr_stb & ~wr_data[POS]),
            .auto_en_i (ctrl.aclr),
            .snap_i    (rd_snap),
            .done_i    (rd_done),
            .flag_o    (flag_vec[i])
         );
      end
   end

   always_comb begin
      status_q           = '0;
      status_q[POS_RTCF] = flag_vec[0];
      status_q[POS_BAT]  = flag_vec[1];
      status_q[POS_ALM]  = flag_vec[2];
      status_q[POS_WREN] = ctrl.wren;
      status_q[POS_XOSC] = ctrl.xosc;
      status_q[POS_ACLR] = ctrl.aclr;
   end

   assign time_wr_en  = ctrl.wren;
   assign osc_ext_sel = ctrl.xosc;
endmodule

// File: rtl/tk_status_ctl_chk.sv
module tk_status_ctl_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_lost_evt,
   input logic             bkup_evt,
   input logic             alarm_evt,
   input logic             wr_stb,
   input logic [REG_W-1:0] wr_data,
   input logic             rd_snap,
   input logic             rd_done,
   input logic             time_wr,
   input logic [REG_W-1:0] status_q,
   input logic             time_wr_en,
   input logic             osc_ext_sel
);
   logic unused_chk;
   assign unused_chk = ^{rd_snap, time_wr_en, osc_ext_sel};

   assert_rtcf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_lost_evt |=> status_q[0]);

   assert_rtcf_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr && !pwr_lost_evt |=> !status_q[0]);

   assert_rtcf_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !pwr_lost_evt && !time_wr |=> status_q[0] == $past(status_q[0]));

   assert_bat_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bkup_evt |=> status_q[1]);

   assert_alm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> status_q[2]);

   assert_bat_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bkup_evt && !status_q[1] |=> !status_q[1]);

   assert_alm_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_evt && !status_q[2] |=> !status_q[2]);

   assert_bat_manual_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[1] && !status_q[7] && !(wr_stb && !wr_data[1]) |=> status_q[1]);

   assert_ctrl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> status_q[7] == $past(wr_data[7]) && status_q[6] == $past(wr_data[6])
                 && status_q[4] == $past(wr_data[4]));

   assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(status_q[7]) && $stable(status_q[6]) && $stable(status_q[4]));

   assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !status_q[5] && !status_q[3]);
endmodule

bind tk_status_ctl tk_status_ctl_chk #(.REG_W(REG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_lost_evt (pwr_lost_evt),
   .bkup_evt     (bkup_evt),
   .alarm_evt    (alarm_evt),
   .wr_stb       (wr_stb),
   .wr_data      (wr_data),
   .rd_snap      (rd_snap),
   .rd_done      (rd_done),
   .time_wr      (time_wr),
   .status_q     (status_q),
   .time_wr_en   (time_wr_en),
   .osc_ext_sel  (osc_ext_sel)
);

// File: tb/tk_status_ctl_tb.sv
`timescale 1ns/1ps
module tk_status_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_lost_evt = 1'b0, bkup_evt = 1'b0, alarm_evt = 1'b0;
   logic       wr_stb = 1'b0, rd_snap = 1'b0, rd_done = 1'b0, time_wr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] status_q;
   logic       time_wr_en, osc_ext_sel;
   int         n_vec = 0;
   int         n_bad = 0;

   always #2.5 clk = ~clk;

   tk_status_ctl #(.REG_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_lost_evt(pwr_lost_evt), .bkup_evt(bkup_evt),
      .alarm_evt(alarm_evt), .wr_stb(wr_stb), .wr_data(wr_data), .rd_snap(rd_snap),
      .rd_done(rd_done), .time_wr(time_wr), .status_q(status_q),
      .time_wr_en(time_wr_en), .osc_ext_sel(osc_ext_sel)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // Apply one cycle of stimulus, then release all pulses 1 ns after the edge.
   task automatic step(input logic p, input logic b, input logic a, input logic ws,
                       input logic [7:0] wd, input logic sn, input logic dn, input logic tw);
      pwr_lost_evt = p; bkup_evt = b; alarm_evt = a; wr_stb = ws; wr_data = wd;
      rd_snap = sn; rd_done = dn; time_wr = tw;
      @(posedge clk); #1;
      pwr_lost_evt = 0; bkup_evt = 0; alarm_evt = 0; wr_stb = 0; wr_data = 8'h00;
      rd_snap = 0; rd_done = 0; time_wr = 0;
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      chk(status_q, 8'h00, "R1 status after reset");
      chk({7'b0, time_wr_en}, 8'h00, "R1 time_wr_en after reset");
      chk({7'b0, osc_ext_sel}, 8'h00, "R1 osc_ext_sel after reset");

      // R2/R4/R8/R9: every write value against all three flags set
      for (int v = 0; v < 256; v++) begin
         step(1, 1, 1, 0, 8'h00, 0, 0, 0);
         chk(status_q & 8'h07, 8'h07, "R3 flags set by events");
         step(0, 0, 0, 1, 8'(v), 0, 0, 0);
         chk(status_q, (8'(v) & 8'hD6) | 8'h01, "R4 R8 R9 R2 write sweep");
         chk({7'b0, time_wr_en}, {7'b0, v[4]}, "R8 time_wr_en");
         chk({7'b0, osc_ext_sel}, {7'b0, v[6]}, "R8 osc_ext_sel");
      end

      // R2: time register write clears power-loss flag, and it re-arms on the event
      step(0, 0, 0, 0, 8'h00, 0, 0, 1);
      chk(status_q & 8'h01, 8'h00, "R2 rtcf cleared by time_wr");
      step(0, 0, 0, 0, 8'h00, 0, 0, 1);
      chk(status_q & 8'h01, 8'h00, "R2 rtcf stays clear");
      step(1, 0, 0, 0, 8'h00, 0, 0, 1);
      chk(status_q & 8'h01, 8'h01, "R7 rtcf set beats time_wr");
      step(0, 0, 0, 1, 8'h00, 0, 0, 0);
      chk(status_q & 8'h01, 8'h01, "R2 rtcf ignores status write");

      // R5/R7: prior state x event x write-clear x read-done x auto-clear enable
      for (int c = 0; c < 32; c++) begin
         logic s, e, w, r, a, expb;
         s = c[0]; e = c[1]; w = c[2]; r = c[3]; a = c[4];
         step(0, 0, 0, 1, {a, 7'b0}, 0, 0, 0);
         if (s) step(0, 1, 0, 0, 8'h00, 0, 0, 0);
         step(0, 0, 0, 0, 8'h00, 1, 0, 0);
         step(0, e, 0, w, {a, 7'b0} | 8'h04, 0, r, 0);
         expb = e | (s & ~w & ~(r & a));
         chk({7'b0, status_q[1]}, {7'b0, expb}, "R5 R7 R4 bat clear cross");
      end

      // R6/R5: alarm arriving mid-read survives; battery seen at snapshot clears
      step(1, 0, 0, 1, 8'h80, 0, 0, 0);
      step(0, 1, 0, 0, 8'h00, 0, 0, 0);
      step(0, 0, 0, 0, 8'h00, 1, 0, 0);
      step(0, 0, 1, 0, 8'h00, 0, 0, 0);
      step(0, 0, 0, 0, 8'h00, 0, 1, 0);
      chk(status_q, 8'h85, "R6 R5 mid-read alarm kept, bat and rtcf per rule");
      step(0, 0, 0, 0, 8'h00, 1, 1, 0);
      chk(status_q, 8'h81, "R5 snapshot and done together clear alarm");
      // R5: auto-clear disabled leaves flags after a read
      step(0, 0, 0, 1, 8'h00, 0, 0, 0);
      step(0, 1, 1, 0, 8'h00, 0, 0, 0);
      step(0, 0, 0, 0, 8'h00, 1, 1, 0);
      chk(status_q, 8'h07, "R5 no auto-clear when disabled");

      summary();
      $finish;
   end
endmodule